// File: doc/BRIEF.md
# XOR State-Register Return Dispatcher

This block chooses where a function returns to without ever reading a return address from writable memory. It holds a private state register that ordinary writes cannot reach. When a call is made, the caller presents the call site's function key. The block XORs that key into the state register, and the result becomes the function ID for the call. The key is also pushed onto a small internal key stack.

On a return, the caller names the index of the function that is returning. The block searches that function's read-only table of allowed caller IDs for an entry equal to the state register. On a match it produces the return location held in that entry, pops the key and XORs it back into the state register, which brings back the value the register had before the call. If nothing matches, the block raises a violation and gives no location.

The tables are fixed logic computed at elaboration, so software cannot alter them. Nested calls stack up as successive XORs and unwind in reverse order. Only direct transfers with encoded destinations are covered.

Top module: `xrd_dispatch`

## Requirements
- R1: After synchronous reset the state register is zero, the key stack is empty, and `ret_loc_valid`, `ret_loc`, `violation` and `overflow_fault` are all low or zero.
- R2: A call accepted on a clock edge replaces the state S with S XOR `call_key` and pushes `call_key` onto the key stack. Function f's table entry e holds the ID 0x8000 | (f<<8) | (e<<4) | 0x5.
- R3: A return to function f whose live entry e holds an ID equal to the state raises `ret_loc_valid` in the following cycle, with `ret_loc` = 0x4000 | (f<<8) | (e<<2). The live entries of function f are those with e <= f mod 8.
- R4: A successful return pops the top key and XORs it into the state, which restores the state held before the matching call. Whenever the key stack is empty, the state is zero.
- R5: Nested calls compose as successive XORs. Their returns succeed in last-in, first-out order, each yielding its own location.
- R6: A return whose state matches no live entry of the named function raises `violation` for one cycle with `ret_loc` = 0 and `ret_loc_valid` low. It leaves the state and the key stack unchanged.
- R7: A return made while the key stack is empty raises `violation` and produces no location.
- R8: A call made while the key stack already holds 8 keys raises `overflow_fault` in the following cycle and is otherwise ignored: neither the state nor the stack changes.
- R9: When `call_valid` and `ret_valid` are both high on the same edge, the return is processed and the call is dropped.
- R10: A table entry that is not live (e > f mod 8) never matches, even when its ID formula equals the state.
- R11: All four outputs are registered one-cycle pulses. They are low or zero in any cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_valid | input | 1 | Call request this cycle |
| call_key | input | 16 | Function key of the call site |
| ret_valid | input | 1 | Return request this cycle |
| ret_func | input | 4 | Index of the returning function |
| ret_loc_valid | output | 1 | Return location is valid |
| ret_loc | output | 16 | Selected return location |
| violation | output | 1 | Return could not be matched |
| overflow_fault | output | 1 | Call refused because the key stack is full |

## Verification
The assertions assume that the IDs within any one function's live entries are distinct, so at most one entry can match a given state. They also assume that the state returns to zero whenever every call has been unwound. The stimulus meets both assumptions: keys are always built as the current modelled state XORed with a legal table ID, and each scenario begins from a fresh reset. The deliberately mismatching and dead-entry returns break only the table match. They never break the pairing between pushed keys and the state.

// File: rtl/xrd_pkg.sv
package xrd_pkg;

    typedef int unsigned u32_t;

    // Outcome of one request, registered into the output pulses
    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_RET  = 2'd1,
        OUT_VIOL = 2'd2,
        OUT_OVF  = 2'd3
    } outcome_e;

    // Allowed caller ID of entry e in function f's read-only table
    function automatic u32_t rom_id(u32_t f, u32_t e, u32_t id_w);
        return (u32_t'(1) << (id_w - 1)) | (f << 8) | (e << 4) | u32_t'(5);
    endfunction

    // Return location stored beside that ID
    function automatic u32_t rom_loc(u32_t f, u32_t e);
        return u32_t'(32'h4000) | (f << 8) | (e << 2);
    endfunction

    // Function f owns (f mod nent)+1 live entries
    function automatic logic entry_live(u32_t f, u32_t e, u32_t nent);
        return e <= (f % nent);
    endfunction

endpackage

// File: rtl/xrd_key_stack.sv
module xrd_key_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] top_idx;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_idx = cnt - CW'(1);
    assign top     = mem[top_idx[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && !full) begin
            mem[cnt[AW-1:0]] <= din;
            cnt              <= cnt + CW'(1);
        end else if (pop && !empty) begin
            cnt <= cnt - CW'(1);
        end
    end

    // R8: occupancy never exceeds the stack depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R8: a push into a full stack leaves the occupancy alone
    assert_full_push_held_R8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/xrd_table_match.sv
module xrd_table_match
    import xrd_pkg::*;
#(
    parameter int ID_W  = 16,
    parameter int LOC_W = 16,
    parameter int NFUNC = 16,
    parameter int NENT  = 8
) (
    input  logic [$clog2(NFUNC)-1:0] func,
    input  logic [ID_W-1:0]          state,
    output logic                     hit,
    output logic [LOC_W-1:0]         loc,
    output logic [NENT-1:0]          hit_vec
);
    // One comparator per table entry; the table itself is fixed logic
    for (genvar e = 0; e < NENT; e++) begin : g_entry
        assign hit_vec[e] = entry_live(u32_t'(func), u32_t'(e), u32_t'(NENT)) &&
                            (ID_W'(rom_id(u32_t'(func), u32_t'(e), u32_t'(ID_W))) == state);
    end

    // Lowest matching index wins
    always_comb begin
        hit = 1'b0;
        loc = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit = 1'b1;
                loc = LOC_W'(rom_loc(u32_t'(func), u32_t'(i)));
            end
        end
    end

endmodule

// File: rtl/xrd_dispatch.sv
module xrd_dispatch
    import xrd_pkg::*;
#(
    parameter int ID_W   = 16,
    parameter int LOC_W  = 16,
    parameter int NFUNC  = 16,
    parameter int NENT   = 8,
    parameter int KDEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     call_valid,
    input  logic [ID_W-1:0]          call_key,
    input  logic                     ret_valid,
    input  logic [$clog2(NFUNC)-1:0] ret_func,
    output logic                     ret_loc_valid,
    output logic [LOC_W-1:0]         ret_loc,
    output logic                     violation,
    output logic                     overflow_fault
);
    logic [ID_W-1:0]  state_q;
    logic [ID_W-1:0]  key_top;
    logic             stk_full, stk_empty;
    logic             tbl_hit;
    logic [LOC_W-1:0] tbl_loc;
    logic [NENT-1:0]  hit_vec;
    logic             do_call, ret_ok, push, pop;
    outcome_e         outcome_d, outcome_q;
    logic [LOC_W-1:0] loc_q;

    xrd_table_match #(
        .ID_W (ID_W),
        .LOC_W(LOC_W),
        .NFUNC(NFUNC),
        .NENT (NENT)
    ) u_table (
        .func   (ret_func),
        .state  (state_q),
        .hit    (tbl_hit),
        .loc    (tbl_loc),
        .hit_vec(hit_vec)
    );

    xrd_key_stack #(
        .W    (ID_W),
        .DEPTH(KDEPTH)
    ) u_keys (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .pop  (pop),
        .din  (call_key),
        .top  (key_top),
        .full (stk_full),
        .empty(stk_empty)
    );

    // A return on the same edge as a call takes precedence
    assign do_call = call_valid && !ret_valid;
    assign ret_ok  = ret_valid && !stk_empty && tbl_hit;
    assign push    = do_call && !stk_full;
    assign pop     = ret_ok;

    always_comb begin
        outcome_d = OUT_NONE;
        if (ret_valid)     outcome_d = ret_ok ? OUT_RET : OUT_VIOL;
        else if (call_valid && stk_full) outcome_d = OUT_OVF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= '0;
            outcome_q <= OUT_NONE;
            loc_q     <= '0;
        end else begin
            if (ret_ok)    state_q <= state_q ^ key_top;
            else if (push) state_q <= state_q ^ call_key;
            outcome_q <= outcome_d;
            loc_q     <= ret_ok ? tbl_loc : '0;
        end
    end

    assign ret_loc_valid  = (outcome_q == OUT_RET);
    assign ret_loc        = loc_q;
    assign violation      = (outcome_q == OUT_VIOL);
    assign overflow_fault = (outcome_q == OUT_OVF);

    // R4: with every call unwound the state register is back at zero
    assert_state_clear_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        stk_empty |-> (state_q == '0));

    // R3: at most one live entry can match the state
    assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R11: a location only follows a return request
    assert_loc_needs_request_R11: assert property (@(posedge clk) disable iff (rst)
        ret_loc_valid |-> $past(ret_valid));

    // R6: a violation never carries a location
    assert_viol_no_loc_R6: assert property (@(posedge clk) disable iff (rst)
        violation |-> (!ret_loc_valid && ret_loc == '0));

    // R8: an overflow fault only follows a lone call
    assert_fault_from_call_R8: assert property (@(posedge clk) disable iff (rst)
        overflow_fault |-> $past(call_valid && !ret_valid));

endmodule

// File: tb/xrd_dispatch_tb.sv
module xrd_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_valid = 1'b0;
    logic [15:0] call_key = '0;
    logic        ret_valid = 1'b0;
    logic [3:0]  ret_func = '0;
    logic        ret_loc_valid;
    logic [15:0] ret_loc;
    logic        violation;
    logic        overflow_fault;

    int checks = 0;
    int failures = 0;

    // Bench model of the state register and key stack (R2, R4)
    logic [15:0] m_state;
    logic [15:0] m_keys [$];

    always #5 clk = ~clk;

    xrd_dispatch u_dut (
        .clk           (clk),
        .rst           (rst),
        .call_valid    (call_valid),
        .call_key      (call_key),
        .ret_valid     (ret_valid),
        .ret_func      (ret_func),
        .ret_loc_valid (ret_loc_valid),
        .ret_loc       (ret_loc),
        .violation     (violation),
        .overflow_fault(overflow_fault)
    );

    function automatic logic [15:0] id_of(int f, int e);
        return 16'h8000 | 16'(f << 8) | 16'(e << 4) | 16'h5;
    endfunction

    function automatic logic [15:0] loc_of(int f, int e);
        return 16'h4000 | 16'(f << 8) | 16'(e << 2);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        call_valid = 1'b0;
        ret_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_state = '0;
        m_keys.delete();
    endtask

    // Drive one request at a negedge; outputs are read one cycle later
    task automatic pulse(logic cv, logic [15:0] key, logic rv, logic [3:0] f);
        @(negedge clk);
        call_valid = cv;
        call_key   = key;
        ret_valid  = rv;
        ret_func   = f;
        @(negedge clk);
        call_valid = 1'b0;
        ret_valid  = 1'b0;
    endtask

    // Call aimed at entry e of function f, key built from the model state
    task automatic call_to(int f, int e, string req);
        logic [15:0] k;
        k = m_state ^ id_of(f, e);
        pulse(1'b1, k, 1'b0, 4'(f));
        chk({req, " call fault"}, {31'd0, overflow_fault}, 32'd0);
        m_state = m_state ^ k;
        m_keys.push_back(k);
    endtask

    task automatic ret_expect_ok(int f, int e, string req);
        pulse(1'b0, '0, 1'b1, 4'(f));
        chk({req, " loc_valid"}, {31'd0, ret_loc_valid}, 32'd1);
        chk({req, " loc"}, {16'd0, ret_loc}, {16'd0, loc_of(f, e)});
        m_state = m_state ^ m_keys.pop_back();
    endtask

    task automatic ret_expect_viol(int f, string req);
        pulse(1'b0, '0, 1'b1, 4'(f));
        chk({req, " violation"}, {31'd0, violation}, 32'd1);
        chk({req, " no loc"}, {15'd0, ret_loc_valid, ret_loc}, 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 outputs idle", {13'd0, ret_loc_valid, violation, overflow_fault, ret_loc}, 32'd0);
        ret_expect_viol(3, "R7 empty return");
    endtask

    task automatic t_single();
        do_reset();
        call_to(5, 2, "R2");
        ret_expect_ok(5, 2, "R3 single return");
        ret_expect_viol(5, "R4 restored to empty");
    endtask

    task automatic t_nested();
        do_reset();
        call_to(7, 6, "R5");
        call_to(1, 1, "R5");
        call_to(9, 0, "R5");
        ret_expect_ok(9, 0, "R5 inner");
        ret_expect_ok(1, 1, "R4 middle");
        ret_expect_ok(7, 6, "R5 outer");
    endtask

    task automatic t_mismatch();
        do_reset();
        call_to(4, 1, "R6");
        ret_expect_viol(6, "R6 wrong table");
        ret_expect_ok(4, 1, "R6 state kept");
        ret_expect_viol(4, "R6 stack kept");
    endtask

    task automatic t_dead_entry();
        do_reset();
        call_to(2, 3, "R10");
        ret_expect_viol(2, "R10 dead entry");
    endtask

    task automatic t_overflow();
        logic [15:0] k;
        do_reset();
        for (int e = 0; e < 8; e++) call_to(7, e, "R8 fill");
        k = m_state ^ id_of(3, 0);
        pulse(1'b1, k, 1'b0, 4'd0);
        chk("R8 overflow fault", {31'd0, overflow_fault}, 32'd1);
        for (int e = 7; e >= 0; e--) ret_expect_ok(7, e, "R8 unwind");
        ret_expect_viol(7, "R8 ninth call dropped");
    endtask

    task automatic t_simultaneous();
        do_reset();
        call_to(3, 0, "R9");
        pulse(1'b1, id_of(8, 0), 1'b1, 4'd3);
        chk("R9 return wins", {15'd0, ret_loc_valid, ret_loc}, {15'd0, 1'b1, loc_of(3, 0)});
        chk("R9 no fault", {31'd0, overflow_fault}, 32'd0);
        ret_expect_viol(8, "R9 call dropped");
    endtask

    task automatic t_pulse_width();
        do_reset();
        call_to(12, 4, "R11");
        ret_expect_ok(12, 4, "R11 return");
        @(negedge clk);
        chk("R11 pulse ended", {13'd0, ret_loc_valid, violation, overflow_fault, ret_loc}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_nested();
        t_mismatch();
        t_dead_entry();
        t_overflow();
        t_simultaneous();
        t_pulse_width();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule